// File: doc/BRIEF.md
# Ternary Operand Fault Screen

This block watches the operand pairs that several ALU issue slots are about to consume and raises a per-slot recovery flag whenever a pair falls inside one of a small set of stored ternary patterns ("cubes"). Each cube carries a compare value, a care mask and the index of the ALU it belongs to. Any bit whose mask bit is clear is a don't-care, so one cube can cover many failing operand pairs. A raised flag tells the pipeline to squash the result and re-issue the operation elsewhere or more slowly. A flag on an operand pair that would in fact have worked is an accepted false alarm. Every pair that really fails must be covered by a loaded cube.

The cube table has no addressed write port. After each power-up, and again whenever a larger cube set has to be installed, an external loader streams cubes in. A one-hot fill token steps through the entries, so the k-th accepted beat lands in entry k. The load channel uses a valid/ready handshake. The block stalls the loader only during the single cycle in which a restart is requested (`ld_ready` is the inverse of `ld_restart`). Beats that arrive after the table is closed or full are still accepted, but they are thrown away.

Top module: `tern_op_screen`

## Requirements
- R1: A cube hits a slot's operands when every key bit whose mask bit is 1 equals the cube's value bit. Bits whose mask bit is 0 are ignored. The key is {A, B}: A occupies bits 2*OP_W-1..OP_W and B occupies bits OP_W-1..0.
- R2: Cubes are stored strictly in arrival order. The k-th beat accepted after reset or restart (k counted from 0) fills entry k. No address is supplied.
- R3: A cube only hits the slot whose index equals the cube's ALU tag. The same operands presented on any other slot produce no flag from that cube.
- R4: Entries that were not filled since the last reset or restart never hit.
- R5: `slot_valid[s]` and `recover[s]` are registered. They reflect the operands presented on the previous clock edge. `recover[s]` can be 1 only when `slot_valid[s]` is 1, and `slot_valid[s]` equals the previous cycle's `op_valid[s]` AND `load_done`.
- R6: While `load_done` is 0, no `recover` or `slot_valid` bit is raised in the following cycle.
- R7: `load_done` rises on the edge that accepts either a beat with `ld_last` set or the beat that fills the last of the ENTRIES entries.
- R8: Once `load_done` is 1, accepted beats change neither the table nor the flags, even an all-don't-care cube. A loader that never sets `ld_last` gets `load_done` after exactly ENTRIES beats.
- R9: A `ld_restart` pulse empties the table, clears `load_done` and returns the fill token to entry 0. `ld_ready` is 0 during that cycle and 1 otherwise.
- R10: After reset, `load_done`, `recover` and `slot_valid` are all 0 and `ld_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_restart | input | 1 | Empty the table and start a new load |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Load beat can be taken (low only while restarting) |
| ld_value | input | 2*OP_W | Cube compare value, {A, B} layout |
| ld_mask | input | 2*OP_W | Cube care mask, 1 = compared |
| ld_alu | input | ID_W | ALU slot the cube belongs to |
| ld_last | input | 1 | Final cube of this load |
| load_done | output | 1 | Table closed, screening active |
| op_valid | input | SLOTS | Slot carries an operation this cycle |
| op_a | input | SLOTS*OP_W | Operand A per slot, slot s at bits s*OP_W upward |
| op_b | input | SLOTS*OP_W | Operand B per slot, same packing |
| slot_valid | output | SLOTS | Registered, qualified slot valid |
| recover | output | SLOTS | Registered recovery flag per slot |

## Verification
A wrong fill-token state makes cubes land in the wrong entry or be lost. This shows up as a missing or extra flag on the first operand pair aimed at that cube, one cycle after the pair is presented. A stale valid bit or `load_done` after a restart shows up as a flag on a pair that the freshly loaded table does not cover. A tag or key-ordering error shows up as a flag on the wrong slot, or on a swapped A/B pair, within one cycle. The bench compares every output on every cycle against a behavioural model, so each of these faults is caught at the first cycle where it becomes visible.

// File: rtl/tern_screen_pkg.sv
package tern_screen_pkg;
  typedef enum logic [0:0] {
    FILL_OPEN   = 1'b0,
    FILL_CLOSED = 1'b1
  } fill_state_e;

  function automatic int id_width(input int slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction
endpackage

// File: rtl/tern_cube_store.sv
module tern_cube_store
  import tern_screen_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int KEY_W   = 64,
  parameter int ID_W    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             wr_offer,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic [ID_W-1:0]  wr_alu,
  input  logic             wr_last,
  output logic [KEY_W-1:0] ent_value [ENTRIES],
  output logic [KEY_W-1:0] ent_mask  [ENTRIES],
  output logic [ID_W-1:0]  ent_alu   [ENTRIES],
  output logic [ENTRIES-1:0] ent_live,
  output logic             closed
);
  fill_state_e         state_q;
  logic [ENTRIES-1:0]  token_q;
  logic                take;
  logic                table_full;

  assign table_full = ~|token_q;
  assign take       = wr_offer && !restart && (state_q == FILL_OPEN) && !table_full;
  assign closed     = (state_q == FILL_CLOSED);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      token_q <= {{(ENTRIES-1){1'b0}}, 1'b1};
      state_q <= FILL_OPEN;
    end else if (take) begin
      token_q <= token_q << 1;
      if (wr_last || token_q[ENTRIES-1]) state_q <= FILL_CLOSED;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
        ent_live[e] <= 1'b0;
      end else if (take && token_q[e]) begin
        ent_live[e] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (take && token_q[e]) begin
        ent_value[e] <= wr_value;
        ent_mask[e]  <= wr_mask;
        ent_alu[e]   <= wr_alu;
      end
    end
  end

  // R2: fill position is one entry or none (table full)
  a_r2_token_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(token_q));
  // R2: fill position moves only when a beat is taken
  a_r2_token_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !restart) |=> $stable(token_q));
  // R7: closing beat closes the table
  a_r7_close_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (wr_last || token_q[ENTRIES-1])) |=> closed);
  // R8: closed table keeps its contents
  a_r8_closed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (closed && !restart) |=> ($stable(ent_live) && closed));
  // R9: restart empties the table
  a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!closed && ent_live == '0 && token_q[0]));
endmodule

// File: rtl/tern_slot_match.sv
module tern_slot_match #(
  parameter int ENTRIES = 32,
  parameter int KEY_W   = 64,
  parameter int ID_W    = 1,
  parameter int SLOT_ID = 0
) (
  input  logic [KEY_W-1:0]   key,
  input  logic [KEY_W-1:0]   ent_value [ENTRIES],
  input  logic [KEY_W-1:0]   ent_mask  [ENTRIES],
  input  logic [ID_W-1:0]    ent_alu   [ENTRIES],
  input  logic [ENTRIES-1:0] ent_live,
  output logic               hit
);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(SLOT_ID);
  logic [ENTRIES-1:0] line_hit;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_line
    assign line_hit[e] = ent_live[e] && (ent_alu[e] == MY_ID) &&
                         (((key ^ ent_value[e]) & ent_mask[e]) == '0);
  end

  assign hit = |line_hit;
endmodule

// File: rtl/tern_op_screen.sv
module tern_op_screen
  import tern_screen_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int OP_W    = 32,
  parameter int SLOTS   = 2,
  localparam int ID_W   = id_width(SLOTS),
  localparam int KEY_W  = 2 * OP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_restart,
  input  logic                  ld_valid,
  output logic                  ld_ready,
  input  logic [KEY_W-1:0]      ld_value,
  input  logic [KEY_W-1:0]      ld_mask,
  input  logic [ID_W-1:0]       ld_alu,
  input  logic                  ld_last,
  output logic                  load_done,
  input  logic [SLOTS-1:0]      op_valid,
  input  logic [SLOTS*OP_W-1:0] op_a,
  input  logic [SLOTS*OP_W-1:0] op_b,
  output logic [SLOTS-1:0]      slot_valid,
  output logic [SLOTS-1:0]      recover
);
  logic [KEY_W-1:0]   ent_value [ENTRIES];
  logic [KEY_W-1:0]   ent_mask  [ENTRIES];
  logic [ID_W-1:0]    ent_alu   [ENTRIES];
  logic [ENTRIES-1:0] ent_live;
  logic [SLOTS-1:0]   slot_hit;
  logic               closed;

  assign ld_ready = !ld_restart;

  tern_cube_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .ID_W(ID_W)) u_store (
    .clk(clk), .rst_n(rst_n), .restart(ld_restart),
    .wr_offer(ld_valid && ld_ready),
    .wr_value(ld_value), .wr_mask(ld_mask), .wr_alu(ld_alu), .wr_last(ld_last),
    .ent_value(ent_value), .ent_mask(ent_mask), .ent_alu(ent_alu),
    .ent_live(ent_live), .closed(closed)
  );

  assign load_done = closed;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    tern_slot_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .ID_W(ID_W), .SLOT_ID(s)) u_match (
      .key({op_a[s*OP_W +: OP_W], op_b[s*OP_W +: OP_W]}),
      .ent_value(ent_value), .ent_mask(ent_mask), .ent_alu(ent_alu),
      .ent_live(ent_live), .hit(slot_hit[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid <= '0;
      recover    <= '0;
    end else begin
      slot_valid <= closed ? op_valid : '0;
      recover    <= closed ? (op_valid & slot_hit) : '0;
    end
  end

  // R5: a flag never appears without its slot valid
  a_r5_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (recover & ~slot_valid) == '0);
  // R6: nothing is flagged while the table is still open
  a_r6_quiet_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |=> (recover == '0 && slot_valid == '0));
  // R9: the loader is stalled only in a restart cycle
  a_r9_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready != ld_restart);
endmodule

// File: tb/tern_op_screen_test.sv
module tern_op_screen_test;
  localparam int ENTRIES = 32;
  localparam int OP_W    = 32;
  localparam int SLOTS   = 2;
  localparam int ID_W    = 1;
  localparam int KEY_W   = 2 * OP_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_restart = 1'b0, ld_valid = 1'b0, ld_last = 1'b0;
  logic [KEY_W-1:0] ld_value = '0, ld_mask = '0;
  logic [ID_W-1:0] ld_alu = '0;
  logic [SLOTS-1:0] op_valid = '0;
  logic [SLOTS*OP_W-1:0] op_a = '0, op_b = '0;
  logic ld_ready, load_done;
  logic [SLOTS-1:0] slot_valid, recover;

  tern_op_screen #(.ENTRIES(ENTRIES), .OP_W(OP_W), .SLOTS(SLOTS)) uut (
    .clk(clk), .rst_n(rst_n), .ld_restart(ld_restart), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_value(ld_value), .ld_mask(ld_mask), .ld_alu(ld_alu),
    .ld_last(ld_last), .load_done(load_done), .op_valid(op_valid), .op_a(op_a),
    .op_b(op_b), .slot_valid(slot_valid), .recover(recover)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  string cur_req = "R10";

  // behavioural reference: a list of cubes in arrival order
  logic [KEY_W-1:0] m_val[$], m_msk[$];
  int m_alu[$];
  bit m_done = 0;
  logic [SLOTS-1:0] exp_rec = '0, exp_sv = '0;

  function automatic bit model_hit(int slot, logic [KEY_W-1:0] key);
    for (int i = 0; i < m_val.size(); i++)
      if (m_alu[i] == slot && ((key ^ m_val[i]) & m_msk[i]) == '0) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_val.delete(); m_msk.delete(); m_alu.delete();
      m_done = 0; exp_rec = '0; exp_sv = '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        exp_sv[s]  = m_done && op_valid[s];
        exp_rec[s] = m_done && op_valid[s] &&
                     model_hit(s, {op_a[s*OP_W +: OP_W], op_b[s*OP_W +: OP_W]});
      end
      if (ld_restart) begin
        m_val.delete(); m_msk.delete(); m_alu.delete(); m_done = 0;
      end else if (ld_valid && !m_done && m_val.size() < ENTRIES) begin
        m_val.push_back(ld_value); m_msk.push_back(ld_mask); m_alu.push_back(int'(ld_alu));
        if (ld_last || m_val.size() == ENTRIES) m_done = 1;
      end
    end
  end

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check("recover", 64'(recover), 64'(exp_rec));
    check("slot_valid", 64'(slot_valid), 64'(exp_sv));
    check("load_done", 64'(load_done), 64'(m_done));
    check("ld_ready", 64'(ld_ready), 64'(!ld_restart));
  end

  task automatic beat(logic [KEY_W-1:0] v, logic [KEY_W-1:0] m, int alu, bit last);
    ld_valid = 1; ld_value = v; ld_mask = m; ld_alu = ID_W'(alu); ld_last = last;
    @(negedge clk);
    ld_valid = 0; ld_last = 0;
  endtask

  task automatic ops(logic [SLOTS-1:0] vld, logic [OP_W-1:0] a0, logic [OP_W-1:0] b0,
                     logic [OP_W-1:0] a1, logic [OP_W-1:0] b1);
    op_valid = vld; op_a = {a1, a0}; op_b = {b1, b0};
    @(negedge clk);
    op_valid = '0;
  endtask

  task automatic restart();
    ld_restart = 1; @(negedge clk); ld_restart = 0;
  endtask

  localparam logic [KEY_W-1:0] BIT4_MASK = (KEY_W'(1) << (OP_W + 4)) | (KEY_W'(1) << 4);

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);                     // R10 checked by compares
    cur_req = "R6";
    beat('0, BIT4_MASK, 0, 0);                     // A4=0,B4=0 on ALU 0
    beat({32'd5, 32'd7}, '1, 1, 0);                // exact A=5,B=7 on ALU 1
    ops(2'b11, 32'h0, 32'h0, 32'd5, 32'd7);        // would hit, but table open
    cur_req = "R7";
    beat({32'hdead, 32'hbeef}, '1, 1, 1);          // closing beat
    @(negedge clk);
    cur_req = "R1";
    ops(2'b01, 32'hffff_ffef, 32'h1234_5600, 0, 0);  // bit 4 zero in both: hit
    ops(2'b01, 32'h0000_0010, 32'h0, 0, 0);          // A4=1: miss
    ops(2'b01, 32'h0, 32'h0000_0010, 0, 0);          // B4=1: miss
    ops(2'b10, 0, 0, 32'd7, 32'd5);                  // swapped A/B: miss
    cur_req = "R3";
    ops(2'b10, 0, 0, 32'h0, 32'h0);                  // ALU0 cube on slot 1: miss
    ops(2'b01, 32'd5, 32'd7, 0, 0);                  // ALU1 cube on slot 0: no cube? 5/7 bit4=0 -> hit via entry0
    ops(2'b11, 32'h10, 32'd7, 32'd5, 32'd7);         // slot0 miss, slot1 hit
    cur_req = "R5";
    ops(2'b00, 32'h0, 32'h0, 32'd5, 32'd7);          // no valid, no flags
    cur_req = "R8";
    beat('0, '0, 0, 0);                              // all-don't-care after close
    beat('0, '0, 1, 1);
    ops(2'b11, 32'h10, 32'h10, 32'h10, 32'h10);      // must still miss
    cur_req = "R9";
    restart();
    ops(2'b11, 32'h0, 32'h0, 32'd5, 32'd7);          // empty/open: quiet
    cur_req = "R4";
    beat({32'h0, 32'hffff_0000}, {32'h0, 32'hffff_0000}, 0, 1);
    for (int i = 0; i < 40; i++)
      ops(2'b11, $urandom, $urandom, $urandom, $urandom);
    ops(2'b01, 32'h1, 32'hffff_0001, 0, 0);          // hit entry 0 only
    cur_req = "R2";
    restart();
    for (int k = 0; k < ENTRIES; k++)
      beat({32'(k), 32'(k * 3)}, '1, k % 2, 0);      // 32nd beat closes
    cur_req = "R8";
    beat('0, '0, 0, 0);                              // full: discarded
    for (int k = 0; k < ENTRIES; k++)
      ops(2'b11, 32'(k), 32'(k * 3), 32'(k), 32'(k * 3));
    ops(2'b11, 32'h77, 32'h99, 32'h77, 32'h99);
    cur_req = "R1";
    restart();
    beat({32'hA000_0000, 32'h0000_000B}, {32'hF000_0000, 32'h0000_000F}, 1, 0);
    beat({32'h0, 32'h8000_0000}, {32'h0, 32'h8000_0000}, 0, 1);
    for (int i = 0; i < 200; i++)
      ops(2'($urandom), {4'hA, 28'($urandom)}, $urandom, {4'($urandom), 28'($urandom)},
          {28'($urandom), 4'hB});
    cur_req = "R10";
    rst_n = 0; @(negedge clk); @(negedge clk);
    rst_n = 1; @(negedge clk); @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule